// File: doc/BRIEF.md
# Data-side address translator with fault classification

This block turns one data-access request per cycle into a physical address, or into a single fault code when the access may not proceed. It takes the virtual address, the access size, the direction, the privilege mode, the low bit of the program counter and four request qualifiers: direct-physical, use-alternate-mode, page-table-walk load and suppress-fault-logging. It also takes the result of an external translation-buffer lookup: a hit bit, a page frame number, per-mode read and write enable masks, and the trap-on-read and trap-on-write bits. The buffer storage itself lives outside the block.

The checks form a fixed priority chain. Misalignment is tested first. Then come the direct-physical bypass, the canonical-address test, a kernel-only direct-mapped window, the buffer miss, and finally permission and trap-on-access. A physical address that falls outside the implemented range is reported last, as a machine check. When a fault is logged, three capture registers take the faulting address, a packed status word and a formatted lookup address. Addresses whose top implemented bit is set are flagged uncacheable and have part of their upper field cleared.

Results are registered, and the response appears one clock after the request.

Top module: `dxlat_unit`

## Requirements
- R1: A request with `req_valid` high yields `rsp_valid` high on the next clock edge, and an idle cycle yields `rsp_valid` low. After reset every output is zero.
- R2: If `vaddr & ((1<<size_log2)-1)` is nonzero, the fault is alignment (code 1). This wins over every other check. The status flags carry only the write bit (bit 0), which is set for writes.
- R3: The effective mode is `cur_mode` when `pc_lsb` is 0. When `pc_lsb` is 1, it is `alt_mode` if `req_alt` is set and kernel (0) otherwise.
- R4: With `req_phys` set, the virtual address passes through unchanged. Otherwise VA bits [63:43] must be all zeros or all ones; if they are not, the fault is page fault (code 3) with flags access-violation (bit 1), bad-address (bit 4) and write-if-writing.
- R5: A canonical VA with bits [47:41] equal to 0x7E maps directly. In a non-kernel mode this gives access violation (code 2), flags access-violation and write-if-writing. In kernel mode the PA is VA[43:0], with bits [43:40] forced to 0xF when bit 40 is 1, and cut to 40 bits when bit 40 is 0.
- R6: Outside the window, a buffer hit gives PA = (ppn << 13) | VA[12:0]. A miss gives code 4 for ordinary requests and code 5 for page-table-walk requests, with flags miss (bit 5) and write-if-writing.
- R7: Permission is the enable-mask bit selected by the effective mode. A denied write gives code 3 with write, access-violation and, when the trap-on-write bit is set, trap-on-write (bit 3). A denied read gives code 2 with access-violation and, when the trap-on-read bit is set, trap-on-read (bit 2). A permitted access whose trap bit is set gives code 3 with trap-on-write plus write, or trap-on-read alone.
- R8: A logged fault loads `flt_va` with the VA, `flt_stat` with {opcode[5:0], ra[4:0], flags[5:0]}, and `flt_vaform` with `ptbr | (VA[42:13] << 3)`.
- R9: Requests flagged page-table-walk or suppress-logging leave all three capture registers unchanged.
- R10: A fault-free PA with any bit at or above bit 44 gives machine check (code 6) and does not touch the capture registers.
- R11: A fault-free PA with bit 43 set raises `rsp_uncache` and clears PA bits [42:35]. Any faulting response carries PA 0 and `rsp_uncache` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_vaddr | input | 64 | Virtual address |
| req_size_log2 | input | 2 | log2 of access size in bytes |
| req_write | input | 1 | 1 = write |
| req_phys | input | 1 | Bypass translation |
| req_alt | input | 1 | Use alternate mode when pc_lsb is set |
| req_vpte | input | 1 | Page-table-walk load |
| req_nofault | input | 1 | Suppress fault logging |
| cur_mode | input | 2 | Current mode (0 = kernel) |
| alt_mode | input | 2 | Alternate mode value |
| pc_lsb | input | 1 | Low bit of program counter |
| inst_opcode | input | 6 | Opcode of the access instruction |
| inst_ra | input | 5 | Register field of the access instruction |
| ptbr | input | 64 | Page-table base for formatted address |
| tlb_hit | input | 1 | Lookup hit |
| tlb_ppn | input | 32 | Page frame number |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_fonr | input | 1 | Trap on read |
| tlb_fonw | input | 1 | Trap on write |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 64 | Physical address (0 on fault) |
| rsp_fault | output | 3 | 0 none, 1 align, 2 access, 3 page, 4 miss, 5 walk miss, 6 machine check |
| rsp_uncache | output | 1 | Uncacheable access |
| flt_va | output | 64 | Captured faulting VA |
| flt_stat | output | 17 | Captured status word |
| flt_vaform | output | 64 | Captured formatted address |

## Verification
The directed patterns cover several cases. A misaligned, non-canonical address shows that alignment outranks every later check. Direct-window addresses with PA bit 40 set and with it clear separate the two sign-extension branches and the uncacheable clearing. Buffer hits whose frame numbers reach bit 43 or bit 44 separate the uncacheable outcome from machine check. Each combination of permission and trap bit, for both reads and writes, yields a distinct code and flag set, and these are read through the status word. The same miss is issued three times, ordinary, walk-flagged and suppress-flagged, to tell the logging suppression apart from the code change.

// File: rtl/dxlat_pkg.sv
package dxlat_pkg;
    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_ALIGN = 3'd1,
        FLT_ACV   = 3'd2,
        FLT_PAGE  = 3'd3,
        FLT_MISS  = 3'd4,
        FLT_VMISS = 3'd5,
        FLT_MCHK  = 3'd6
    } flt_e;

    localparam int FLAG_W   = 6;
    localparam int OPC_W    = 6;
    localparam int RA_W     = 5;
    localparam int STAT_W   = OPC_W + RA_W + FLAG_W;
    localparam int FB_WR    = 0;
    localparam int FB_ACV   = 1;
    localparam int FB_FONR  = 2;
    localparam int FB_FONW  = 3;
    localparam int FB_BADVA = 4;
    localparam int FB_MISS  = 5;

    localparam int           WIN_HI     = 47;
    localparam int           WIN_LO     = 41;
    localparam logic [6:0]   WIN_TAG    = 7'h7E;
    localparam int           PA_SX_BIT  = 40;
    localparam int           UNC_CLR_LO = 35;
    localparam int           FORM_SHIFT = 3;
endpackage

// File: rtl/dxlat_mode.sv
module dxlat_mode #(
    parameter int MODE_W = 2
) (
    input  logic [MODE_W-1:0] cur_mode,
    input  logic [MODE_W-1:0] alt_mode,
    input  logic              pc_lsb,
    input  logic              use_alt,
    output logic [MODE_W-1:0] eff_mode
);
    always_comb begin
        if (!pc_lsb)      eff_mode = cur_mode;
        else if (use_alt) eff_mode = alt_mode;
        else              eff_mode = '0;
    end
endmodule

// File: rtl/dxlat_check.sv
module dxlat_check
    import dxlat_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int VA_IMPL  = 43,
    parameter int PA_IMPL  = 44,
    parameter int PG_SHIFT = 13,
    parameter int PPN_W    = 32,
    parameter int MODE_W   = 2
) (
    input  logic [VA_W-1:0]        vaddr,
    input  logic [1:0]             size_log2,
    input  logic                   write,
    input  logic                   phys,
    input  logic                   vpte,
    input  logic [MODE_W-1:0]      mode,
    input  logic                   tlb_hit,
    input  logic [PPN_W-1:0]       tlb_ppn,
    input  logic [(1<<MODE_W)-1:0] tlb_rd_en,
    input  logic [(1<<MODE_W)-1:0] tlb_wr_en,
    input  logic                   tlb_fonr,
    input  logic                   tlb_fonw,
    output flt_e                   fault,
    output logic [FLAG_W-1:0]      flags,
    output logic [VA_W-1:0]        paddr,
    output logic                   uncache,
    output logic                   log_fault
);
    localparam logic [VA_W-1:0] ONE       = VA_W'(1);
    localparam logic [VA_W-1:0] IMPL_MASK = (ONE << PA_IMPL) - ONE;
    localparam logic [VA_W-1:0] LOW_MASK  = (ONE << PA_SX_BIT) - ONE;
    localparam logic [VA_W-1:0] SX_BITS   = IMPL_MASK & ~LOW_MASK;

    logic [VA_W-1:0]         align_mask;
    logic [VA_W-VA_IMPL-1:0] unimpl;
    logic                    canon;
    logic                    win_hit;
    logic [VA_W-1:0]         raw_pa;
    logic [VA_W-1:0]         tlb_pa;

    assign align_mask = (ONE << size_log2) - ONE;
    assign unimpl     = vaddr[VA_W-1:VA_IMPL];
    assign canon      = (&unimpl) || !(|unimpl);
    assign win_hit    = (vaddr[WIN_HI:WIN_LO] == WIN_TAG);
    assign tlb_pa     = (VA_W'(tlb_ppn) << PG_SHIFT) | VA_W'(vaddr[PG_SHIFT-1:0]);

    always_comb begin
        fault   = FLT_NONE;
        flags   = '0;
        raw_pa  = '0;
        paddr   = '0;
        uncache = 1'b0;
        flags[FB_WR] = write;
        if (|(vaddr & align_mask)) begin
            fault = FLT_ALIGN;
        end else if (phys) begin
            raw_pa = vaddr;
        end else if (!canon) begin
            fault            = FLT_PAGE;
            flags[FB_BADVA]  = 1'b1;
            flags[FB_ACV]    = 1'b1;
        end else if (win_hit) begin
            if (mode != '0) begin
                fault         = FLT_ACV;
                flags[FB_ACV] = 1'b1;
            end else begin
                raw_pa = vaddr & IMPL_MASK;
                if (raw_pa[PA_SX_BIT]) raw_pa = raw_pa | SX_BITS;
                else                   raw_pa = raw_pa & LOW_MASK;
            end
        end else if (!tlb_hit) begin
            fault          = vpte ? FLT_VMISS : FLT_MISS;
            flags[FB_MISS] = 1'b1;
        end else begin
            raw_pa = tlb_pa;
            if (write) begin
                if (!tlb_wr_en[mode]) begin
                    fault          = FLT_PAGE;
                    flags[FB_ACV]  = 1'b1;
                    flags[FB_FONW] = tlb_fonw;
                end else if (tlb_fonw) begin
                    fault          = FLT_PAGE;
                    flags[FB_FONW] = 1'b1;
                end
            end else begin
                if (!tlb_rd_en[mode]) begin
                    fault          = FLT_ACV;
                    flags[FB_ACV]  = 1'b1;
                    flags[FB_FONR] = tlb_fonr;
                end else if (tlb_fonr) begin
                    fault          = FLT_PAGE;
                    flags[FB_FONR] = 1'b1;
                end
            end
        end
        if (fault == FLT_NONE) begin
            if (|raw_pa[VA_W-1:PA_IMPL]) begin
                fault = FLT_MCHK;
            end else begin
                paddr = raw_pa;
                if (paddr[PA_IMPL-1]) begin
                    uncache                         = 1'b1;
                    paddr[PA_IMPL-2:UNC_CLR_LO]     = '0;
                end
            end
        end
        log_fault = (fault != FLT_NONE) && (fault != FLT_MCHK);
    end
endmodule

// File: rtl/dxlat_unit.sv
module dxlat_unit
    import dxlat_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int VA_IMPL  = 43,
    parameter int PA_IMPL  = 44,
    parameter int PG_SHIFT = 13,
    parameter int PPN_W    = 32,
    parameter int MODE_W   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [VA_W-1:0]        req_vaddr,
    input  logic [1:0]             req_size_log2,
    input  logic                   req_write,
    input  logic                   req_phys,
    input  logic                   req_alt,
    input  logic                   req_vpte,
    input  logic                   req_nofault,
    input  logic [MODE_W-1:0]      cur_mode,
    input  logic [MODE_W-1:0]      alt_mode,
    input  logic                   pc_lsb,
    input  logic [OPC_W-1:0]       inst_opcode,
    input  logic [RA_W-1:0]        inst_ra,
    input  logic [VA_W-1:0]        ptbr,
    input  logic                   tlb_hit,
    input  logic [PPN_W-1:0]       tlb_ppn,
    input  logic [(1<<MODE_W)-1:0] tlb_rd_en,
    input  logic [(1<<MODE_W)-1:0] tlb_wr_en,
    input  logic                   tlb_fonr,
    input  logic                   tlb_fonw,
    output logic                   rsp_valid,
    output logic [VA_W-1:0]        rsp_paddr,
    output logic [2:0]             rsp_fault,
    output logic                   rsp_uncache,
    output logic [VA_W-1:0]        flt_va,
    output logic [STAT_W-1:0]      flt_stat,
    output logic [VA_W-1:0]        flt_vaform
);
    localparam int VPN_W = VA_IMPL - PG_SHIFT;

    typedef struct packed {
        logic              vld;
        logic [VA_W-1:0]   pa;
        flt_e              fault;
        logic              unc;
        logic [VA_W-1:0]   fva;
        logic [STAT_W-1:0] stat;
        logic [VA_W-1:0]   form;
    } st_t;

    st_t st_d, st_q;

    logic [MODE_W-1:0] eff_mode;
    flt_e              chk_fault;
    logic [FLAG_W-1:0] chk_flags;
    logic [VA_W-1:0]   chk_pa;
    logic              chk_unc;
    logic              chk_log;
    logic [VPN_W-1:0]  vpn;

    dxlat_mode #(.MODE_W(MODE_W)) u_mode (
        .cur_mode (cur_mode),
        .alt_mode (alt_mode),
        .pc_lsb   (pc_lsb),
        .use_alt  (req_alt),
        .eff_mode (eff_mode)
    );

    dxlat_check #(
        .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PA_IMPL(PA_IMPL),
        .PG_SHIFT(PG_SHIFT), .PPN_W(PPN_W), .MODE_W(MODE_W)
    ) u_check (
        .vaddr     (req_vaddr),
        .size_log2 (req_size_log2),
        .write     (req_write),
        .phys      (req_phys),
        .vpte      (req_vpte),
        .mode      (eff_mode),
        .tlb_hit   (tlb_hit),
        .tlb_ppn   (tlb_ppn),
        .tlb_rd_en (tlb_rd_en),
        .tlb_wr_en (tlb_wr_en),
        .tlb_fonr  (tlb_fonr),
        .tlb_fonw  (tlb_fonw),
        .fault     (chk_fault),
        .flags     (chk_flags),
        .paddr     (chk_pa),
        .uncache   (chk_unc),
        .log_fault (chk_log)
    );

    assign vpn = req_vaddr[VA_IMPL-1:PG_SHIFT];

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid;
        if (req_valid) begin
            st_d.pa    = chk_pa;
            st_d.fault = chk_fault;
            st_d.unc   = chk_unc;
            if (chk_log && !req_vpte && !req_nofault) begin
                st_d.fva  = req_vaddr;
                st_d.stat = {inst_opcode, inst_ra, chk_flags};
                st_d.form = ptbr | (VA_W'(vpn) << FORM_SHIFT);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid   = st_q.vld;
    assign rsp_paddr   = st_q.pa;
    assign rsp_fault   = st_q.fault;
    assign rsp_uncache = st_q.unc;
    assign flt_va      = st_q.fva;
    assign flt_stat    = st_q.stat;
    assign flt_vaform  = st_q.form;

    p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_quiet_regs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_vpte || req_nofault)) |=>
            ($stable(flt_va) && $stable(flt_stat) && $stable(flt_vaform)));
    p_pa_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 3'd0) |-> (rsp_paddr[VA_W-1:PA_IMPL] == '0));
    p_unc_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_uncache |-> (rsp_paddr[PA_IMPL-1] && rsp_paddr[PA_IMPL-2:UNC_CLR_LO] == '0));
    p_fault_no_pa_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 3'd0) |-> (rsp_paddr == '0 && !rsp_uncache));
    p_align_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_vaddr[0] && req_size_log2 != 2'd0) |=> (rsp_fault == 3'd1));
endmodule

// File: tb/dxlat_unit_bench.sv
module dxlat_unit_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid, req_write, req_phys, req_alt, req_vpte, req_nofault, pc_lsb;
    logic [63:0] req_vaddr, ptbr;
    logic [1:0]  req_size_log2, cur_mode, alt_mode;
    logic [5:0]  inst_opcode;
    logic [4:0]  inst_ra;
    logic        tlb_hit, tlb_fonr, tlb_fonw;
    logic [31:0] tlb_ppn;
    logic [3:0]  tlb_rd_en, tlb_wr_en;
    logic        rsp_valid, rsp_uncache;
    logic [63:0] rsp_paddr, flt_va, flt_vaform;
    logic [2:0]  rsp_fault;
    logic [16:0] flt_stat;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [5:0]  OPC  = 6'h2B;
    localparam logic [4:0]  RAF  = 5'h0D;
    localparam logic [63:0] BASE = 64'h0000_0010_0000_0000;

    always #5 clk = ~clk;

    dxlat_unit u_dxlat_unit (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] form_of(input logic [63:0] va);
        return BASE | ({34'b0, va[42:13]} << 3);
    endfunction

    task automatic defaults();
        req_valid = 0; req_vaddr = 0; req_size_log2 = 0; req_write = 0;
        req_phys = 0; req_alt = 0; req_vpte = 0; req_nofault = 0;
        cur_mode = 0; alt_mode = 0; pc_lsb = 0;
        inst_opcode = OPC; inst_ra = RAF; ptbr = BASE;
        tlb_hit = 1; tlb_ppn = 0; tlb_rd_en = 4'hF; tlb_wr_en = 4'hF;
        tlb_fonr = 0; tlb_fonw = 0;
    endtask

    task automatic issue();
        req_valid = 1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic expect_ok(input string tag, input logic [63:0] pa, input logic unc);
        chk({tag, " valid"}, {63'b0, rsp_valid}, 64'd1);
        chk({tag, " fault"}, {61'b0, rsp_fault}, 64'd0);
        chk({tag, " pa"}, rsp_paddr, pa);
        chk({tag, " unc"}, {63'b0, rsp_uncache}, {63'b0, unc});
    endtask

    task automatic expect_flt(input string tag, input logic [2:0] code, input logic [5:0] fl,
                              input logic [63:0] va);
        chk({tag, " fault"}, {61'b0, rsp_fault}, {61'b0, code});
        chk({tag, " pa zero R11"}, rsp_paddr, 64'd0);
        chk({tag, " stat R8"}, {47'b0, flt_stat}, {47'b0, OPC, RAF, fl});
        chk({tag, " va R8"}, flt_va, va);
        chk({tag, " form R8"}, flt_vaform, form_of(va));
    endtask

    task automatic t_reset();
        chk("R1 reset valid", {63'b0, rsp_valid}, 0);
        chk("R1 reset fault", {61'b0, rsp_fault}, 0);
        chk("R1 reset fva", flt_va, 0);
        chk("R1 reset stat", {47'b0, flt_stat}, 0);
    endtask

    task automatic t_align();
        defaults();
        req_vaddr = 64'h0001_0000_0000_0002; req_size_log2 = 2; req_write = 1;
        issue();
        expect_flt("R2 misaligned beats bad VA", 3'd1, 6'h01, req_vaddr);
        defaults();
        issue();
        defaults();
        @(negedge clk);
        chk("R1 idle valid low", {63'b0, rsp_valid}, 0);
    endtask

    task automatic t_phys();
        defaults();
        req_phys = 1; req_vaddr = 64'h0000_0123_4567_89A0; req_size_log2 = 3;
        issue();
        expect_ok("R4 phys pass", 64'h0000_0123_4567_89A0, 0);
        defaults();
        req_vaddr = 64'h0000_8000_0000_0000;
        issue();
        expect_flt("R4 bad VA", 3'd3, 6'h12, 64'h0000_8000_0000_0000);
    endtask

    task automatic t_window();
        defaults();
        req_vaddr = 64'hFFFF_FD00_0000_2000;
        issue();
        expect_ok("R5 R11 window bit40 set", 64'h0000_0800_0000_2000, 1);
        req_vaddr = 64'hFFFF_FC12_3456_7000;
        issue();
        expect_ok("R5 window bit40 clear", 64'h0000_0012_3456_7000, 0);
        cur_mode = 3; req_write = 1;
        issue();
        expect_flt("R5 window user", 3'd2, 6'h03, 64'hFFFF_FC12_3456_7000);
    endtask

    task automatic t_mode();
        defaults();
        req_vaddr = 64'hFFFF_FC12_3456_7000; cur_mode = 3; pc_lsb = 1;
        issue();
        expect_ok("R3 pc lsb forces kernel", 64'h0000_0012_3456_7000, 0);
        req_alt = 1; alt_mode = 2;
        issue();
        chk("R3 alt mode used", {61'b0, rsp_fault}, 64'd2);
        defaults();
        req_vaddr = 64'h0000_0000_0060_1A38; tlb_ppn = 32'h0001_2345; tlb_rd_en = 4'b0100;
        pc_lsb = 1; req_alt = 1; alt_mode = 2;
        issue();
        expect_ok("R3 alt mode permits", 64'h0000_0000_2468_BA38, 0);
    endtask

    task automatic t_tlb();
        logic [63:0] sva, sst, sfm;
        defaults();
        req_vaddr = 64'h0000_0000_0060_1A38; tlb_ppn = 32'h0001_2345;
        issue();
        expect_ok("R6 hit", 64'h0000_0000_2468_BA38, 0);
        tlb_ppn = 32'h4FC0_0001;
        issue();
        expect_ok("R11 uncached via frame", 64'h0000_0800_0000_3A38, 1);
        tlb_ppn = 32'h8000_0000;
        sva = flt_va; sst = {47'b0, flt_stat}; sfm = flt_vaform;
        issue();
        chk("R10 machine check", {61'b0, rsp_fault}, 64'd6);
        chk("R10 regs kept", flt_va, sva);
        chk("R10 stat kept", {47'b0, flt_stat}, sst);
        chk("R10 form kept", flt_vaform, sfm);
        defaults();
        req_vaddr = 64'h0000_0000_0040_2008; tlb_hit = 0;
        issue();
        expect_flt("R6 miss", 3'd4, 6'h20, 64'h0000_0000_0040_2008);
        req_vaddr = 64'h0000_0000_0080_4010; req_vpte = 1;
        issue();
        chk("R6 walk miss code", {61'b0, rsp_fault}, 64'd5);
        chk("R9 walk keeps va", flt_va, 64'h0000_0000_0040_2008);
        req_vpte = 0; req_nofault = 1; req_write = 1;
        issue();
        chk("R9 nofault code", {61'b0, rsp_fault}, 64'd4);
        chk("R9 nofault keeps va", flt_va, 64'h0000_0000_0040_2008);
        chk("R9 nofault keeps stat", {47'b0, flt_stat}, {47'b0, OPC, RAF, 6'h20});
    endtask

    task automatic t_perm();
        defaults();
        req_vaddr = 64'h0000_0000_0060_1A38; tlb_ppn = 32'h0001_2345;
        req_write = 1; tlb_wr_en = 4'b1110; tlb_fonw = 1;
        issue();
        expect_flt("R7 write denied", 3'd3, 6'h0B, req_vaddr);
        req_write = 0; tlb_rd_en = 4'b1110; tlb_fonr = 1; tlb_fonw = 0;
        issue();
        expect_flt("R7 read denied", 3'd2, 6'h06, req_vaddr);
        tlb_rd_en = 4'hF;
        issue();
        expect_flt("R7 read trap", 3'd3, 6'h04, req_vaddr);
        tlb_fonr = 0; req_write = 1; tlb_wr_en = 4'hF; tlb_fonw = 1;
        issue();
        expect_flt("R7 write trap", 3'd3, 6'h09, req_vaddr);
        tlb_fonw = 0;
        issue();
        expect_ok("R7 write allowed", 64'h0000_0000_2468_BA38, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        defaults();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_align();
        t_phys();
        t_window();
        t_mode();
        t_tlb();
        t_perm();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule